// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This block is a clocked behavioural model of a byte-wide static RAM in which every word has a shadow nonvolatile copy. Four active-low controls are sampled on each clock: chip select, write strobe, output strobe and nonvolatile select. Together they pick one of six commands: deselect, no-operation, read, write, save-to-shadow (store) and load-from-shadow (recall). The address and the bidirectional data bus appear as a plain address input, a data input, a data output and an output-enable.

Store and recall are self-timed transfers between the working array and the shadow array. Each takes a parameterised number of clock cycles, and `busy` is high for all of them. A transfer starts only on the clock in which the controls newly enter its command condition. While it runs, every input is ignored and the data output is not driven. The transfer is done as a one-word-per-cycle sweep: a clearing pass over the target array, then a copy pass.

Top module: `nvram_ctrl`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `we_n`=1, `nv_n`=1 and `busy` low, `dout_en` is 1 and `dout` shows the working word at `addr` in the same cycle, following address changes without a clock edge.
- R2: With `ce_n`=0, `we_n`=0, `nv_n`=1 and `busy` low, the rising clock edge writes `din` into the working word at `addr`; `oe_n` does not matter.
- R3: A clock in which the controls are `ce_n`=0, `we_n`=0, `nv_n`=0, `oe_n`=1 and were not so on the previous clock starts a store. `busy` rises after that edge and stays high for exactly max(STORE_CYC, 2*2^AW) cycles. The shadow array is first cleared to zero and then loaded with the whole working array.
- R4: A clock in which the controls are `ce_n`=0, `oe_n`=0, `nv_n`=0, `we_n`=1 and were not so on the previous clock starts a recall. `busy` is high for exactly max(RECALL_CYC, 2*2^AW) cycles. The working array is cleared and then loaded from the shadow array, and the shadow array is left unchanged.
- R5: If the controls still hold the store or recall condition when the operation ends, no second operation starts and `busy` stays low.
- R6: While `busy` is high, writes are not performed and `dout_en` is 0, whatever the controls are.
- R7: On the first clock after `busy` falls, a read or write condition on the controls takes effect.
- R8: During a write with `oe_n`=0, `dout_en` is 0.
- R9: With `ce_n`=1, `dout_en` is 0 and no store or recall starts, whatever the other controls are.
- R10: With `ce_n`=0 and `nv_n`=0, the pairs (`we_n`,`oe_n`)=(0,0) and (1,1) are no-operation: nothing is written, `busy` stays low and `dout_en` is 0.
- R11: After the synchronous active-high reset, `busy` is 0. With `ce_n`=1 at that time, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data from the working array |
| dout_en | output | 1 | Data output driver enable |
| busy | output | 1 | Store or recall in progress |

## Verification
The control decode is exercised with each legal read and write pattern, with write under both output-strobe levels, with deselect combined with the other strobes held in store-like and read-like positions, and with both nonvolatile no-operation pairs. Together these separate the decode priorities. Each transfer is entered once from deselect and once held until it completes; the held case shows that starting is edge-based and not level-based. Writes issued during a transfer, and words changed between a store and two later recalls, show whether the transfer really moved data, whether writes were blocked while it ran, and whether the shadow copy survived a recall. The exact length of `busy` is counted for each transfer, and an output check in the first idle cycle covers the immediate return to normal access.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL  = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_READ   = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_STORE  = 3'd4,
    CMD_RECALL = 3'd5
  } cmd_e;

  // Map the four active-low strobes to one command.
  function automatic cmd_e decode_ctl(input logic ce_n, input logic we_n,
                                      input logic oe_n, input logic nv_n);
    cmd_e c;
    if (ce_n)                c = CMD_DESEL;
    else if (nv_n) begin
      if (!we_n)             c = CMD_WRITE;
      else if (!oe_n)        c = CMD_READ;
      else                   c = CMD_NOP;
    end
    else if (!we_n && oe_n)  c = CMD_STORE;
    else if (we_n && !oe_n)  c = CMD_RECALL;
    else                     c = CMD_NOP;
    return c;
  endfunction

endpackage

// File: rtl/nvram_cmd_decode.sv
module nvram_cmd_decode
  import nvram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic nv_n,
  input  logic busy,
  output cmd_e cmd,
  output logic start_store,
  output logic start_recall
);

  cmd_e prev_q;

  always_comb cmd = decode_ctl(ce_n, we_n, oe_n, nv_n);

  // Previous command is tracked even while busy, so a level that is
  // still held when a transfer ends is not seen as a new entry.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= CMD_DESEL;
    else     prev_q <= cmd;
  end

  assign start_store  = !busy && (cmd == CMD_STORE)  && (prev_q != CMD_STORE);
  assign start_recall = !busy && (cmd == CMD_RECALL) && (prev_q != CMD_RECALL);

  AST_START_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_store && start_recall)); // R3

endmodule

// File: rtl/nvram_xfer.sv
module nvram_xfer #(
  parameter int AW         = 9,
  parameter int STORE_LEN  = 1040,
  parameter int RECALL_LEN = 1032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_store,
  input  logic          start_recall,
  output logic          busy,
  output logic          xf_we_work,
  output logic          xf_we_shadow,
  output logic          xf_clear,
  output logic [AW-1:0] xf_idx
);

  localparam int DEPTH   = 1 << AW;
  localparam int MAX_LEN = (STORE_LEN > RECALL_LEN) ? STORE_LEN : RECALL_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             busy_q;
  logic             recall_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_len;
  logic             in_clear;
  logic             in_copy;

  assign cur_len  = recall_q ? CNT_W'(RECALL_LEN) : CNT_W'(STORE_LEN);
  assign in_clear = busy_q && (cnt_q < CNT_W'(DEPTH));
  assign in_copy  = busy_q && (cnt_q >= CNT_W'(DEPTH)) && (cnt_q < CNT_W'(2 * DEPTH));

  // One word per cycle: first a clearing sweep, then a copy sweep.
  assign xf_idx       = cnt_q[AW-1:0];
  assign xf_clear     = in_clear;
  assign xf_we_work   = recall_q  && (in_clear || in_copy);
  assign xf_we_shadow = !recall_q && (in_clear || in_copy);
  assign busy         = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      recall_q <= 1'b0;
      cnt_q    <= '0;
    end else if (busy_q) begin
      if (cnt_q == cur_len - CNT_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end else if (start_store || start_recall) begin
      busy_q   <= 1'b1;
      recall_q <= start_recall;
      cnt_q    <= '0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < cur_len)); // R3

  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(recall_q)); // R4

endmodule

// File: rtl/nvram_arrays.sv
module nvram_arrays #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          user_we,
  input  logic [AW-1:0] user_addr,
  input  logic [DW-1:0] user_din,
  input  logic          xf_we_work,
  input  logic          xf_we_shadow,
  input  logic          xf_clear,
  input  logic [AW-1:0] xf_idx,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] work_mem   [DEPTH];
  logic [DW-1:0] shadow_mem [DEPTH];

  logic          work_we;
  logic [AW-1:0] work_waddr;
  logic [DW-1:0] work_wdata;
  logic [DW-1:0] shadow_wdata;

  // Single write port per array; the transfer engine has priority.
  assign work_we      = xf_we_work || user_we;
  assign work_waddr   = xf_we_work ? xf_idx : user_addr;
  assign work_wdata   = xf_we_work ? (xf_clear ? '0 : shadow_mem[xf_idx]) : user_din;
  assign shadow_wdata = xf_clear ? '0 : work_mem[xf_idx];

  always_ff @(posedge clk) begin
    if (work_we) work_mem[work_waddr] <= work_wdata;
  end

  always_ff @(posedge clk) begin
    if (xf_we_shadow) shadow_mem[xf_idx] <= shadow_wdata;
  end

  assign rd_data = work_mem[user_addr];

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(user_we && (xf_we_work || xf_we_shadow))); // R6

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(xf_we_work && xf_we_shadow)); // R4

endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
  import nvram_pkg::*;
#(
  parameter int AW         = 9,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 1040,
  parameter int RECALL_CYC = 1032
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          nv_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy
);

  localparam int DEPTH      = 1 << AW;
  localparam int MIN_LEN    = 2 * DEPTH;
  localparam int STORE_LEN  = (STORE_CYC  < MIN_LEN) ? MIN_LEN : STORE_CYC;
  localparam int RECALL_LEN = (RECALL_CYC < MIN_LEN) ? MIN_LEN : RECALL_CYC;

  cmd_e          cmd;
  logic          start_store;
  logic          start_recall;
  logic          busy_i;
  logic          xf_we_work;
  logic          xf_we_shadow;
  logic          xf_clear;
  logic [AW-1:0] xf_idx;
  logic          user_we;

  nvram_cmd_decode u_decode (
    .clk          (clk),
    .rst          (rst),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .oe_n         (oe_n),
    .nv_n         (nv_n),
    .busy         (busy_i),
    .cmd          (cmd),
    .start_store  (start_store),
    .start_recall (start_recall)
  );

  nvram_xfer #(
    .AW         (AW),
    .STORE_LEN  (STORE_LEN),
    .RECALL_LEN (RECALL_LEN)
  ) u_xfer (
    .clk          (clk),
    .rst          (rst),
    .start_store  (start_store),
    .start_recall (start_recall),
    .busy         (busy_i),
    .xf_we_work   (xf_we_work),
    .xf_we_shadow (xf_we_shadow),
    .xf_clear     (xf_clear),
    .xf_idx       (xf_idx)
  );

  assign user_we = (cmd == CMD_WRITE) && !busy_i;

  nvram_arrays #(
    .AW (AW),
    .DW (DW)
  ) u_arrays (
    .clk          (clk),
    .rst          (rst),
    .user_we      (user_we),
    .user_addr    (addr),
    .user_din     (din),
    .xf_we_work   (xf_we_work),
    .xf_we_shadow (xf_we_shadow),
    .xf_clear     (xf_clear),
    .xf_idx       (xf_idx),
    .rd_data      (dout)
  );

  assign dout_en = (cmd == CMD_READ) && !busy_i;
  assign busy    = busy_i;

  AST_BUSY_HIZ: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dout_en); // R6

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> !dout_en); // R9

  AST_WRITE_NODRIVE: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |-> !dout_en); // R8

  AST_STORE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ce_n && !we_n && !nv_n && oe_n && (cmd != $past(cmd))) |=> busy); // R3

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && (cmd == $past(cmd)) && ((cmd == CMD_STORE) || (cmd == CMD_RECALL)))
      |=> !busy); // R5

endmodule

// File: tb/test_nvram_ctrl.sv
module test_nvram_ctrl;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int STORE_LEN  = 1040;  // max(1040, 2*512)
  localparam int RECALL_LEN = 1032;  // max(1032, 2*512)

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, nv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int run_cnt = 0;
  int last_run = 0;

  always #10 clk = ~clk;

  nvram_ctrl i_nvram_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .nv_n(nv_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  // Scoreboard queues (parallel): check mask, expected values, tag.
  typedef struct packed {
    logic          ck_busy;
    logic          exp_busy;
    logic          ck_en;
    logic          exp_en;
    logic          ck_data;
    logic [DW-1:0] exp_data;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input exp_t e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare every pending expectation away from the active edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e.ck_busy) check(busy === e.exp_busy, t, "busy", int'(busy), int'(e.exp_busy));
      if (e.ck_en)   check(dout_en === e.exp_en, t, "dout_en", int'(dout_en), int'(e.exp_en));
      if (e.ck_data) check(dout === e.exp_data, t, "dout", int'(dout), int'(e.exp_data));
    end
  end

  // Length of the most recent busy run, counted at negative edges.
  always @(negedge clk) begin
    if (rst) run_cnt = 0;
    else if (busy === 1'b1) run_cnt++;
    else if (run_cnt != 0) begin
      last_run = run_cnt;
      run_cnt = 0;
    end
  end

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic ctl(input logic c, input logic w, input logic o, input logic n);
    ce_n = c; we_n = w; oe_n = o; nv_n = n;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic o);
    ctl(1'b0, 1'b0, o, 1'b1);
    addr = a; din = d;
    tick();
  endtask

  task automatic exp_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    ctl(1'b0, 1'b1, 1'b0, 1'b1);
    addr = a;
    push('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, d}, tag);
    tick();
  endtask

  task automatic deselect;
    ctl(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
  endtask

  task automatic wait_idle(input int len, input string tag);
    do @(negedge clk); while (busy === 1'b1);
    #1;
    check(last_run == len, tag, "busy length", last_run, len);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    push('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R11");
    tick();

    // R2 writes, with output strobe high and low
    do_write(9'h005, 8'h3C, 1'b1);
    do_write(9'h1FF, 8'hA5, 1'b1);
    do_write(9'h000, 8'h81, 1'b1);
    ctl(1'b0, 1'b0, 1'b0, 1'b1);
    addr = 9'h100; din = 8'h5A;
    push('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R8");
    tick();

    // R1 reads following address changes
    exp_read(9'h005, 8'h3C, "R1");
    exp_read(9'h1FF, 8'hA5, "R1");
    exp_read(9'h000, 8'h81, "R2");
    exp_read(9'h100, 8'h5A, "R8");

    // R9 deselect dominates
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    push('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R9");
    tick();
    ctl(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    push('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R9");
    tick();

    // R10 nonvolatile no-operation pairs
    addr = 9'h005; din = 8'h66;
    ctl(1'b0, 1'b0, 1'b0, 1'b0);
    tick();
    push('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R10");
    tick();
    deselect();
    ctl(1'b0, 1'b1, 1'b1, 1'b0);
    tick();
    push('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R10");
    tick();
    deselect();
    exp_read(9'h005, 8'h3C, "R10");

    // R3 store; R6 reads and writes ignored while busy
    deselect();
    ctl(1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    ctl(1'b0, 1'b1, 1'b0, 1'b1);
    addr = 9'h005;
    push('{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, "R3");
    tick();
    do_write(9'h005, 8'hEE, 1'b1);
    wait_idle(STORE_LEN, "R3");
    deselect();
    exp_read(9'h005, 8'h3C, "R6");

    // Change working words after the store
    do_write(9'h005, 8'h11, 1'b1);
    do_write(9'h1FF, 8'h22, 1'b1);
    exp_read(9'h005, 8'h11, "R2");

    // R4 recall, R7 read in first idle cycle
    deselect();
    ctl(1'b0, 1'b1, 1'b0, 1'b0);
    tick();
    ctl(1'b0, 1'b1, 1'b0, 1'b1);
    addr = 9'h1FF;
    push('{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}, "R4");
    wait_idle(RECALL_LEN, "R4");
    check(dout_en === 1'b1, "R7", "dout_en", int'(dout_en), 1);
    check(dout === 8'hA5, "R7", "dout", int'(dout), 8'hA5);
    tick();
    exp_read(9'h005, 8'h3C, "R4");

    // R4 shadow untouched by a recall
    do_write(9'h005, 8'h77, 1'b1);
    deselect();
    ctl(1'b0, 1'b1, 1'b0, 1'b0);
    tick();
    wait_idle(RECALL_LEN, "R4");
    tick();
    deselect();
    exp_read(9'h005, 8'h3C, "R4");

    // R7 write present at completion takes effect
    deselect();
    ctl(1'b0, 1'b1, 1'b0, 1'b0);
    tick();
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    addr = 9'h000; din = 8'h42;
    wait_idle(RECALL_LEN, "R4");
    tick();
    deselect();
    exp_read(9'h000, 8'h42, "R7");

    // R5 held store condition does not retrigger
    deselect();
    ctl(1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    wait_idle(STORE_LEN, "R5");
    for (int i = 0; i < 4; i++) begin
      push('{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, "R5");
      tick();
    end

    deselect();
    tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule